// File: doc/BRIEF.md
# Prioritized Masking Interrupt Controller

This block gathers level-sensitive hardware interrupt lines and four timer-style fast interrupt lines for a single CPU. Each hardware source has a software trigger bit that is ORed with its line, and every source, hardware or fast, has one mask bit. When any source is requesting and unmasked, the block raises a registered request output towards the CPU.

The CPU learns which source to service by strobing a dedicated event read port. In that strobe cycle the block picks the winning source and sets its mask bit, so a read both reports and acknowledges the source. The reported word appears on the cycle after the strobe. Software unmasks the source through the register port once it has serviced it. Mask bits and trigger bits are changed through write-one-to-set and write-one-to-clear words, and each group can be read back.

The event path is a two-state machine. EV_IDLE waits for a strobe. A strobe in EV_IDLE takes the READ_START transition to EV_SHOW, where the captured word is presented with a valid flag. A strobe in EV_SHOW takes READ_AGAIN, which stays in EV_SHOW and presents the next word. A cycle without a strobe in EV_SHOW takes READ_DONE back to EV_IDLE.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A hardware source is pending while (its line OR its software trigger bit) is high and its mask bit is clear; `irq_o` is registered and goes high on the clock edge after a source becomes pending.
- R2: Mask bits reset to all ones (all masked). Word addresses 0..3 set mask bits (write 1 to set), 4..7 clear them (write 1 to clear), with word w covering sources 32w..32w+31. A read of either address returns the mask word, valid with `bus_rvalid_o` one cycle after the read strobe. A masked source is never delivered and does not raise `irq_o`.
- R3: Software trigger bits reset to zero. Addresses 8..11 set them and 12..15 clear them, with the same word layout. A read of either address returns the trigger word. A trigger bit stays set, also across an acknowledge, until it is cleared.
- R4: Priority: any pending fast source beats every hardware source. Within each kind the lowest number wins.
- R5: An event read strobe in cycle N yields `evt_valid_o` high in cycle N+1, with `evt_data_o` holding bit 31 = 1 (event present), bits [30:16] = type (0 hardware, 1 fast), and bits [15:0] = source number.
- R6: In the strobe cycle the winner's mask bit is set, so it is not reported again until it is unmasked.
- R7: A strobe while nothing unmasked is pending returns all zeros and changes no mask bit.
- R8: `irq_o` stays high in the cycle after an acknowledge and drops one cycle later when no other source is pending.
- R9: The four fast sources are numbered 0..3. Their mask bits reset to ones, are set by bits [3:0] written to address 16, are cleared through address 17, and read back in bits [3:0] of either address.
- R10: Strobes on consecutive cycles deliver the successive winners in priority order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq_i | input | NUM_HW | Level hardware interrupt lines |
| fiq_i | input | 4 | Fast timer interrupt lines |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| evt_rd_i | input | 1 | Event read/acknowledge strobe |
| evt_data_o | output | 32 | Event word |
| evt_valid_o | output | 1 | Event word valid |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Register writes take effect at the edge that samples them. Read data and event words are due one cycle after their strobe. `irq_o` follows the pending state one cycle late. The bench drives and samples on falling edges, so every result is read exactly one falling edge after the edge that produces it. The driver pushes each expected event word, computed from the bench's own mask, trigger and line model, into a queue in the strobe cycle. The monitor pops and compares on every falling edge where `evt_valid_o` is high. The request timing around an acknowledge is checked on the two falling edges that follow the strobe.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int FIQ_N  = 4;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;

    // register groups selected by address bits [4:2]
    localparam logic [2:0] GRP_MSET = 3'd0;
    localparam logic [2:0] GRP_MCLR = 3'd1;
    localparam logic [2:0] GRP_SSET = 3'd2;
    localparam logic [2:0] GRP_SCLR = 3'd3;
    localparam logic [2:0] GRP_FAST = 3'd4;

    typedef enum logic [0:0] {
        EV_IDLE = 1'b0,
        EV_SHOW = 1'b1
    } ev_state_e;
endpackage

// File: rtl/prio_irq_pick.sv
module prio_irq_pick
    import prio_irq_pkg::*;
#(
    parameter int NUM_HW = 64,
    localparam int IDXW  = $clog2(NUM_HW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] hw_pend_i,
    input  logic [FIQ_N-1:0]  fiq_pend_i,
    output logic              win_valid_o,
    output logic              win_fiq_o,
    output logic [IDXW-1:0]   win_num_o
);
    always_comb begin
        win_valid_o = 1'b0;
        win_fiq_o   = 1'b0;
        win_num_o   = '0;
        for (int i = NUM_HW - 1; i >= 0; i--) begin
            if (hw_pend_i[i]) begin
                win_valid_o = 1'b1;
                win_num_o   = IDXW'(i);
            end
        end
        for (int i = FIQ_N - 1; i >= 0; i--) begin
            if (fiq_pend_i[i]) begin
                win_valid_o = 1'b1;
                win_fiq_o   = 1'b1;
                win_num_o   = IDXW'(i);
            end
        end
    end

    // R4
    hw_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o && !win_fiq_o) |->
            (fiq_pend_i == '0) && hw_pend_i[win_num_o] &&
            ((hw_pend_i & ((NUM_HW'(1) << win_num_o) - NUM_HW'(1))) == '0));
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_HW = 64,
    localparam int NW    = NUM_HW / WORD_W,
    localparam int IDXW  = $clog2(NUM_HW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [WORD_W-1:0]  bus_wdata_i,
    output logic [WORD_W-1:0]  bus_rdata_o,
    output logic               bus_rvalid_o,
    input  logic               ack_i,
    input  logic               ack_fiq_i,
    input  logic [IDXW-1:0]    ack_num_i,
    output logic [NUM_HW-1:0]  mask_o,
    output logic [NUM_HW-1:0]  swtrig_o,
    output logic [FIQ_N-1:0]   fmask_o
);
    logic [NUM_HW-1:0] mask_q, mask_d, sw_q, sw_d;
    logic [FIQ_N-1:0]  fm_q, fm_d;
    logic [WORD_W-1:0] rdata_d, rdata_q;
    logic              rvalid_q;
    logic [2:0]        grp;
    logic [1:0]        wsel;
    logic              wr, sw_clr_hit;

    assign grp  = bus_addr_i[4:2];
    assign wsel = bus_addr_i[1:0];
    assign wr   = bus_en_i && bus_we_i;
    assign sw_clr_hit = wr && (grp == GRP_SCLR);

    always_comb begin
        mask_d = mask_q;
        sw_d   = sw_q;
        fm_d   = fm_q;
        if (wr) begin
            for (int w = 0; w < NW; w++) begin
                if (wsel == 2'(w)) begin
                    unique case (grp)
                        GRP_MSET: mask_d[w*WORD_W +: WORD_W] = mask_q[w*WORD_W +: WORD_W] | bus_wdata_i;
                        GRP_MCLR: mask_d[w*WORD_W +: WORD_W] = mask_q[w*WORD_W +: WORD_W] & ~bus_wdata_i;
                        GRP_SSET: sw_d[w*WORD_W +: WORD_W]   = sw_q[w*WORD_W +: WORD_W] | bus_wdata_i;
                        GRP_SCLR: sw_d[w*WORD_W +: WORD_W]   = sw_q[w*WORD_W +: WORD_W] & ~bus_wdata_i;
                        default: ;
                    endcase
                end
            end
            if (grp == GRP_FAST) begin
                if (wsel == 2'd0) fm_d = fm_q | bus_wdata_i[FIQ_N-1:0];
                if (wsel == 2'd1) fm_d = fm_q & ~bus_wdata_i[FIQ_N-1:0];
            end
        end
        // acknowledge wins over a clear in the same cycle
        if (ack_i) begin
            if (ack_fiq_i) fm_d[ack_num_i[1:0]] = 1'b1;
            else           mask_d[ack_num_i]    = 1'b1;
        end
    end

    always_comb begin
        rdata_d = '0;
        for (int w = 0; w < NW; w++) begin
            if (wsel == 2'(w)) begin
                if (grp == GRP_MSET || grp == GRP_MCLR) rdata_d = mask_q[w*WORD_W +: WORD_W];
                if (grp == GRP_SSET || grp == GRP_SCLR) rdata_d = sw_q[w*WORD_W +: WORD_W];
            end
        end
        if (grp == GRP_FAST && (wsel == 2'd0 || wsel == 2'd1))
            rdata_d = {{(WORD_W-FIQ_N){1'b0}}, fm_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '1;
            sw_q     <= '0;
            fm_q     <= '1;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            mask_q   <= mask_d;
            sw_q     <= sw_d;
            fm_q     <= fm_d;
            rvalid_q <= bus_en_i && !bus_we_i;
            if (bus_en_i && !bus_we_i) rdata_q <= rdata_d;
        end
    end

    assign mask_o       = mask_q;
    assign swtrig_o     = sw_q;
    assign fmask_o      = fm_q;
    assign bus_rdata_o  = rdata_q;
    assign bus_rvalid_o = rvalid_q;

    // R6
    ack_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !ack_fiq_i) |=> mask_q[$past(ack_num_i)]);

    // R3
    sw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_clr_hit |=> ((sw_q & $past(sw_q)) == $past(sw_q)));
endmodule

// File: rtl/prio_irq_event.sv
module prio_irq_event
    import prio_irq_pkg::*;
#(
    parameter int NUM_HW = 64,
    localparam int IDXW  = $clog2(NUM_HW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_rd_i,
    input  logic              win_valid_i,
    input  logic              win_fiq_i,
    input  logic [IDXW-1:0]   win_num_i,
    output logic              ack_o,
    output logic [WORD_W-1:0] evt_data_o,
    output logic              evt_valid_o
);
    ev_state_e         state_q, state_d;
    logic [WORD_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE: if (evt_rd_i)  state_d = EV_SHOW;  // READ_START
            EV_SHOW: if (!evt_rd_i) state_d = EV_IDLE;  // READ_DONE, else READ_AGAIN
            default: state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (evt_rd_i)
                data_q <= win_valid_i ? {1'b1, 14'd0, win_fiq_i, 16'(win_num_i)} : '0;
        end
    end

    always_comb begin
        ack_o       = evt_rd_i && win_valid_i;
        evt_valid_o = (state_q == EV_SHOW);
        evt_data_o  = evt_valid_o ? data_q : '0;
    end

    // R5
    evt_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd_i |=> evt_valid_o);

    // R7
    evt_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_o && !evt_data_o[31]) |-> (evt_data_o == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_HW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] hw_irq_i,
    input  logic [3:0]        fiq_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [4:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              bus_rvalid_o,
    input  logic              evt_rd_i,
    output logic [31:0]       evt_data_o,
    output logic              evt_valid_o,
    output logic              irq_o
);
    localparam int IDXW = $clog2(NUM_HW);

    logic [NUM_HW-1:0] mask, swtrig, hw_pend;
    logic [FIQ_N-1:0]  fmask, fiq_pend;
    logic              win_valid, win_fiq, ack;
    logic [IDXW-1:0]   win_num;
    logic              irq_q;

    assign hw_pend  = (hw_irq_i | swtrig) & ~mask;
    assign fiq_pend = fiq_i & ~fmask;

    prio_irq_regs #(.NUM_HW(NUM_HW)) u_regs (
        .clk, .rst_n, .bus_en_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
        .bus_rdata_o, .bus_rvalid_o,
        .ack_i(ack), .ack_fiq_i(win_fiq), .ack_num_i(win_num),
        .mask_o(mask), .swtrig_o(swtrig), .fmask_o(fmask)
    );

    prio_irq_pick #(.NUM_HW(NUM_HW)) u_pick (
        .clk, .rst_n, .hw_pend_i(hw_pend), .fiq_pend_i(fiq_pend),
        .win_valid_o(win_valid), .win_fiq_o(win_fiq), .win_num_o(win_num)
    );

    prio_irq_event #(.NUM_HW(NUM_HW)) u_event (
        .clk, .rst_n, .evt_rd_i,
        .win_valid_i(win_valid), .win_fiq_i(win_fiq), .win_num_i(win_num),
        .ack_o(ack), .evt_data_o, .evt_valid_o
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= win_valid;
    end
    assign irq_o = irq_q;

    // R8
    irq_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hw_pend) == '0 && $past(fiq_pend) == '0) |-> !irq_o);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int NHW = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NHW-1:0] hw = '0;
    logic [3:0] fiq = '0;
    logic bus_en = 0, bus_we = 0, evt_rd = 0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, evt_data;
    logic bus_rvalid, evt_valid, irq;

    int compared = 0, mismatched = 0;
    bit done = 0;

    // bench-side model
    logic [NHW-1:0] m_mask = '1, m_sw = '0;
    logic [3:0] m_fm = '1;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    prio_irq_ctrl #(.NUM_HW(NHW)) i_prio_irq_ctrl (
        .clk, .rst_n, .hw_irq_i(hw), .fiq_i(fiq),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
        .evt_rd_i(evt_rd), .evt_data_o(evt_data), .evt_valid_o(evt_valid), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected event words
    always @(negedge clk) begin
        if (rst_n && evt_valid) begin
            if (exp_q.size() == 0) check("R5 unexpected event", evt_data, 32'hDEAD_BEEF);
            else check("R5/R6 event word", evt_data, exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        for (int w = 0; w < NHW / 32; w++) begin
            if (a == 5'(w))      m_mask[w*32 +: 32] = m_mask[w*32 +: 32] | d;
            if (a == 5'(4 + w))  m_mask[w*32 +: 32] = m_mask[w*32 +: 32] & ~d;
            if (a == 5'(8 + w))  m_sw[w*32 +: 32]   = m_sw[w*32 +: 32] | d;
            if (a == 5'(12 + w)) m_sw[w*32 +: 32]   = m_sw[w*32 +: 32] & ~d;
        end
        if (a == 5'd16) m_fm = m_fm | d[3:0];
        if (a == 5'd17) m_fm = m_fm & ~d[3:0];
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
        check({req, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
        check(req, bus_rdata, exp);
    endtask

    // driver: n consecutive strobes, each expectation from the model
    task automatic evt_read(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_rd = 1;
            begin
                logic [3:0] fp;
                logic [NHW-1:0] hp;
                logic [31:0] e;
                fp = fiq & ~m_fm;
                hp = (hw | m_sw) & ~m_mask;
                e = '0;
                for (int i = NHW - 1; i >= 0; i--) if (hp[i]) e = 32'h8000_0000 | 32'(i);
                for (int i = 3; i >= 0; i--) if (fp[i]) e = 32'h8001_0000 | 32'(i);
                exp_q.push_back(e);
                if (e[31]) begin
                    if (e[16]) m_fm[e[1:0]] = 1'b1;
                    else       m_mask[e[5:0]] = 1'b1;
                end
            end
        end
        @(negedge clk);
        evt_rd = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R2, R3, R9)
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        bus_read(5'd0, 32'hFFFF_FFFF, "R2 mask reset w0");
        bus_read(5'd5, 32'hFFFF_FFFF, "R2 mask reset w1");
        bus_read(5'd8, 32'h0, "R3 trig reset");
        bus_read(5'd16, 32'h0000_000F, "R9 fast mask reset");

        // R7: empty read changes nothing
        bus_write(5'd4, 32'h0000_0020);
        evt_read(1);
        bus_read(5'd0, 32'hFFFF_FFDF, "R7 mask unchanged by empty read");

        // R1, R5, R6, R8: line 5
        @(negedge clk); hw[5] = 1;
        @(negedge clk);
        check("R1 irq rises", {31'd0, irq}, 32'd1);
        evt_read(1);                 // now one negedge after the strobe edge
        check("R8 irq held one cycle", {31'd0, irq}, 32'd1);
        @(negedge clk);
        check("R8 irq drops", {31'd0, irq}, 32'd0);
        bus_read(5'd4, 32'hFFFF_FFFF, "R6 mask set by ack");
        hw[5] = 0;

        // R2: a masked line is blocked
        @(negedge clk); hw[7] = 1;
        repeat (2) @(negedge clk);
        check("R2 masked line no irq", {31'd0, irq}, 32'd0);
        evt_read(1);
        hw[7] = 0;
        bus_write(5'd4, 32'h0000_0400);
        bus_write(5'd0, 32'h0000_0400);
        bus_read(5'd0, 32'hFFFF_FFFF, "R2 set after clear");

        // R4, R10: lines 3 and 40, back-to-back strobes
        hw[3] = 1; hw[40] = 1;
        bus_write(5'd4, 32'h0000_0008);
        bus_write(5'd5, 32'h0000_0100);
        evt_read(3);
        hw[3] = 0; hw[40] = 0;

        // R3: software trigger on source 33
        bus_write(5'd9, 32'h0000_0002);
        bus_write(5'd5, 32'h0000_0002);
        evt_read(1);
        bus_read(5'd9, 32'h0000_0002, "R3 trigger persists after ack");
        bus_write(5'd13, 32'h0000_0002);
        bus_read(5'd13, 32'h0, "R3 trigger cleared");
        bus_write(5'd5, 32'h0000_0002);
        evt_read(1);

        // R9, R4: fast source 2 beats hardware source 1
        fiq[2] = 1; hw[1] = 1;
        bus_write(5'd17, 32'h0000_0004);
        bus_write(5'd4, 32'h0000_0002);
        evt_read(2);
        bus_read(5'd17, 32'h0000_000F, "R9 fast mask set by ack");
        fiq[2] = 0; hw[1] = 0;

        repeat (3) @(negedge clk);
        check("R5 all events delivered", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule